// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the bytes of received Ethernet frames and decides whether a frame is a wake-up frame. The receive path feeds it every frame byte, from the first destination byte through the last of the four FCS bytes. The stream has start-of-frame and end-of-frame strobes and an address-filter verdict. The block checks the frame's CRC-32 itself. It also scans the frame for a wake pattern: a run of at least six 0xFF bytes, followed directly by the station address repeated sixteen times.

The wake decision is taken only on the byte that carries the end-of-frame strobe, and only if four things hold together. The CRC residue must be good, the filter flag must be set, wake must be enabled, and at least one complete pattern must have been seen anywhere in the frame. When the decision is positive, a sticky status bit is set and the active-low event output goes low. Both stay that way until software pulses the clear input.

The byte input uses valid/ready. The block never applies back-pressure once it is out of reset: `in_ready` rises on the first clock edge after reset is released and then stays high. A byte is consumed on every rising edge where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low may sit anywhere inside a frame and have no effect. `in_sof` and `in_eof` are read only on cycles that consume a byte.

Top module: `wake_frame_detector`

## Requirements
- R1: `in_ready` is low while `rst_n` is low, goes high at the first rising edge after reset is released, and then stays high. A byte is taken only when `in_valid` and `in_ready` are both high, and idle cycles inside a frame change nothing.
- R2: A wake pattern is six or more consecutive 0xFF bytes followed at once by sixteen back-to-back copies of the station address. Each copy is sent as `station_addr[47:40]` first and `station_addr[7:0]` last.
- R3: A run of more than six 0xFF bytes still counts as sync. The first byte that is not 0xFF after the run is compared with address byte 0.
- R4: A byte that does not match during the sixteen copies abandons the pattern. If that byte is 0xFF, it counts as the first byte of a new sync run.
- R5: A frame may hold several patterns, including broken ones. Any one complete pattern, anywhere in the frame, is enough.
- R6: The CRC is the reflected CRC-32 (polynomial 0x04C11DB7, preset to all ones), run over every byte including the FCS. The FCS is the complement of the data CRC, sent low byte first. The frame is good only if the final register holds 0xDEBB20E3, which is 0xC704DD7B in normal bit order. A bad FCS never causes a wake.
- R7: `filter_pass`, sampled with the end-of-frame byte, must be 1 for a wake.
- R8: `wake_en`, sampled with the end-of-frame byte, must be 1 for a wake.
- R9: When a qualifying end-of-frame byte is taken at a rising edge, `pme_status` is 1 and `pme_n` is 0 from that edge on.
- R10: `pme_status` stays set, and `pme_n` stays low, until a cycle with `status_clr` high. The edge that ends that cycle clears the status and releases `pme_n`. A wake in the same cycle takes precedence over the clear.
- R11: Every start-of-frame byte restarts both the pattern search and the CRC. A pattern found in a frame that never saw its end-of-frame strobe causes no wake.
- R12: After reset, `pme_status` is 0 and `pme_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A frame byte is offered |
| in_ready | output | 1 | Block accepts bytes (high whenever out of reset) |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Offered byte is the first of a frame |
| in_eof | input | 1 | Offered byte is the last FCS byte of a frame |
| filter_pass | input | 1 | Destination address passed the receive filter |
| station_addr | input | 48 | Station address; bits 47:40 are sent first |
| wake_en | input | 1 | Wake detection enable |
| status_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| pme_status | output | 1 | Sticky wake status |
| pme_n | output | 1 | Power-management event, active low |

## Verification
Every internal fault in this block shows up at one point only: the edge that takes an end-of-frame byte, where the status is either set or not. A corrupted CRC register, a sync counter that fails to saturate, or a repeat counter that is off by one all stay hidden until the following frame ends. They then appear as a missing or spurious wake in the cycle after that edge. The stimulus is therefore built as short frames that each stress one rule: a long sync run, a restart on 0xFF, fifteen copies, a bad FCS, an aborted frame, and idle gaps. Each frame is judged on the cycle right after its end-of-frame byte, so a fault is pinned to the frame that exposes it.

// File: rtl/wake_det_pkg.sv
package wake_det_pkg;

  localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE_REFL = 32'hDEBB20E3;

  typedef enum logic [0:0] {
    SEEK_SYNC = 1'b0,
    SEEK_ADDR = 1'b1
  } seek_phase_e;

  // One byte through the reflected CRC-32 register.
  function automatic logic [31:0] crc_byte(input logic [31:0] cur, input logic [7:0] b);
    logic [31:0] c;
    c = cur ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/wk_crc_unit.sv
module wk_crc_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       sof,
  input  logic [7:0] data,
  output logic       good_now
);
  import wake_det_pkg::*;

  logic [31:0] crc_q;
  logic [31:0] crc_base;
  logic [31:0] crc_nxt;

  always_comb begin
    crc_base = sof ? 32'hFFFF_FFFF : crc_q;
    crc_nxt  = crc_byte(crc_base, data);
    good_now = (crc_nxt == CRC_RESIDUE_REFL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
    else if (take) crc_q <= crc_nxt;
  end

endmodule

// File: rtl/wk_pattern_seek.sv
module wk_pattern_seek #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned REPEATS    = 16,
  parameter int unsigned SYNC_MIN   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    sof,
  input  logic [7:0]              data,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  output logic                    seen_now
);
  import wake_det_pkg::*;

  localparam int unsigned SYNC_W = $clog2(SYNC_MIN + 1);
  localparam int unsigned IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int unsigned REP_W  = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam logic [SYNC_W-1:0] SYNC_FULL = SYNC_W'(SYNC_MIN);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(ADDR_BYTES - 1);
  localparam logic [REP_W-1:0]  REP_LAST  = REP_W'(REPEATS - 1);

  logic [7:0] addr_b [ADDR_BYTES];

  // Byte 0 is the first one on the wire (most significant octet).
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addr_b[g] = station_addr[8*(ADDR_BYTES-1-g) +: 8];
  end

  seek_phase_e       phase_q, phase_b, phase_n;
  logic [SYNC_W-1:0] ffc_q, ffc_b, ffc_n;
  logic [IDX_W-1:0]  idx_q, idx_b, idx_n, pos_idx;
  logic [REP_W-1:0]  rep_q, rep_b, rep_n, pos_rep;
  logic              found_q, found_b;
  logic              is_ff, advance, hit;

  always_comb begin
    phase_b = sof ? SEEK_SYNC : phase_q;
    ffc_b   = sof ? '0 : ffc_q;
    idx_b   = sof ? '0 : idx_q;
    rep_b   = sof ? '0 : rep_q;
    found_b = sof ? 1'b0 : found_q;
    is_ff   = (data == 8'hFF);

    if (phase_b == SEEK_SYNC) begin
      advance = (ffc_b == SYNC_FULL) && !is_ff && (data == addr_b[0]);
      pos_idx = '0;
      pos_rep = '0;
    end else begin
      advance = (data == addr_b[idx_b]);
      pos_idx = idx_b;
      pos_rep = rep_b;
    end

    phase_n = phase_b;
    ffc_n   = ffc_b;
    idx_n   = idx_b;
    rep_n   = rep_b;
    hit     = 1'b0;

    if (advance) begin
      ffc_n = '0;
      if (pos_idx == IDX_LAST && pos_rep == REP_LAST) begin
        hit     = 1'b1;
        phase_n = SEEK_SYNC;
        idx_n   = '0;
        rep_n   = '0;
      end else if (pos_idx == IDX_LAST) begin
        phase_n = SEEK_ADDR;
        idx_n   = '0;
        rep_n   = pos_rep + REP_W'(1);
      end else begin
        phase_n = SEEK_ADDR;
        idx_n   = pos_idx + IDX_W'(1);
        rep_n   = pos_rep;
      end
    end else if (phase_b == SEEK_SYNC) begin
      if (is_ff) ffc_n = (ffc_b == SYNC_FULL) ? ffc_b : ffc_b + SYNC_W'(1);
      else       ffc_n = '0;
    end else begin
      // Broken copy: restart the search, a 0xFF opens a new sync run.
      phase_n = SEEK_SYNC;
      idx_n   = '0;
      rep_n   = '0;
      ffc_n   = is_ff ? SYNC_W'(1) : '0;
    end

    seen_now = found_b | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SEEK_SYNC;
      ffc_q   <= '0;
      idx_q   <= '0;
      rep_q   <= '0;
      found_q <= 1'b0;
    end else if (take) begin
      phase_q <= phase_n;
      ffc_q   <= ffc_n;
      idx_q   <= idx_n;
      rep_q   <= rep_n;
      found_q <= found_b | hit;
    end
  end

endmodule

// File: rtl/wk_event_latch.sv
module wk_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic status
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status <= 1'b0;
    else if (set) status <= 1'b1;
    else if (clr) status <= 1'b0;
  end

endmodule

// File: rtl/wake_frame_detector.sv
module wake_frame_detector #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned REPEATS    = 16,
  parameter int unsigned SYNC_MIN   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic                    filter_pass,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic                    wake_en,
  input  logic                    status_clr,
  output logic                    pme_status,
  output logic                    pme_n
);

  logic ready_q;
  logic take;
  logic crc_good;
  logic pat_seen;
  logic wake_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign take     = in_valid & ready_q;

  wk_crc_unit u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .sof      (in_sof),
    .data     (in_data),
    .good_now (crc_good)
  );

  wk_pattern_seek #(
    .ADDR_BYTES (ADDR_BYTES),
    .REPEATS    (REPEATS),
    .SYNC_MIN   (SYNC_MIN)
  ) u_seek (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .sof          (in_sof),
    .data         (in_data),
    .station_addr (station_addr),
    .seen_now     (pat_seen)
  );

  assign wake_set = take & in_eof & crc_good & pat_seen & filter_pass & wake_en;

  wk_event_latch u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (wake_set),
    .clr    (status_clr),
    .status (pme_status)
  );

  assign pme_n = ~pme_status;

endmodule

// File: rtl/wake_frame_detector_chk.sv
module wake_frame_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_eof,
  input logic filter_pass,
  input logic wake_en,
  input logic status_clr,
  input logic pme_status
);

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R9
  rise_at_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme_status) |-> $past(in_valid && in_ready && in_eof));

  // R7 R8
  rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme_status) |-> $past(filter_pass && wake_en));

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_status && !status_clr) |=> pme_status);

  // R10
  clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pme_status) |-> $past(status_clr));

endmodule

bind wake_frame_detector wake_frame_detector_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_eof      (in_eof),
  .filter_pass (filter_pass),
  .wake_en     (wake_en),
  .status_clr  (status_clr),
  .pme_status  (pme_status)
);

// File: tb/wake_frame_detector_bench.sv
module wake_frame_detector_bench;

  localparam logic [47:0] STATION = 48'h02_1A_3C_5E_70_9B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        filter_pass = 1'b0;
  logic [47:0] station_addr = STATION;
  logic        wake_en = 1'b0;
  logic        status_clr = 1'b0;
  logic        pme_status;
  logic        pme_n;

  int total = 0;
  int bad   = 0;

  logic [7:0] pl[$];
  bit         exp_q[$];
  string      tag_q[$];
  bit         model_status = 1'b0;

  always #10 clk = ~clk;

  wake_frame_detector u_wake_frame_detector (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .in_sof       (in_sof),
    .in_eof       (in_eof),
    .filter_pass  (filter_pass),
    .station_addr (station_addr),
    .wake_en      (wake_en),
    .status_clr   (status_clr),
    .pme_status   (pme_status),
    .pme_n        (pme_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Bit-serial CRC model of R6.
  function automatic logic [31:0] fcs_of(input logic [7:0] bytes_in[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (bytes_in[n]) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ bytes_in[n][i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic add_ff(input int n);
    for (int i = 0; i < n; i++) pl.push_back(8'hFF);
  endtask

  task automatic add_addr(input int reps);
    for (int r = 0; r < reps; r++)
      for (int i = 0; i < 6; i++) pl.push_back(STATION[47-8*i -: 8]);
  endtask

  task automatic add_pad(input int n, input logic [7:0] b);
    for (int i = 0; i < n; i++) pl.push_back(b);
  endtask

  task automatic drive_byte(input logic [7:0] b, input bit s, input bit e);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // Header (destination + source) + pl + FCS; expected item queued first.
  task automatic send_frame(input bit corrupt, input bit fpass, input bit en,
                            input bit gaps, input bit qualifies, input string tag);
    logic [7:0] fr[$];
    logic [31:0] fcs;
    for (int i = 0; i < 6; i++) fr.push_back(STATION[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) fr.push_back(8'h10 + 8'(i));
    fr.push_back(8'h08); fr.push_back(8'h42);
    foreach (pl[i]) fr.push_back(pl[i]);
    fcs = fcs_of(fr);
    if (corrupt) fcs = fcs ^ 32'h0000_0100;
    for (int i = 0; i < 4; i++) fr.push_back(fcs[8*i +: 8]);
    model_status = model_status | qualifies;
    exp_q.push_back(model_status);
    tag_q.push_back(tag);
    filter_pass = fpass;
    wake_en = en;
    foreach (fr[i]) begin
      if (gaps && (i % 3 == 1)) idle_cycle();
      drive_byte(fr[i], i == 0, i == fr.size() - 1);
    end
    idle_cycle();
    idle_cycle();
    idle_cycle();
    pl.delete();
  endtask

  task automatic send_unterminated();
    drive_byte(8'h55, 1'b1, 1'b0);
    foreach (pl[i]) drive_byte(pl[i], 1'b0, 1'b0);
    idle_cycle();
    pl.delete();
  endtask

  task automatic clear_status(input string tag);
    @(negedge clk);
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
    model_status = 1'b0;
    // R10: the clear has taken effect at the edge that ended the pulse
    check(pme_status == 1'b0, "R10", {tag, " status after clear"}, 32'(pme_status), 0);
    check(pme_n == 1'b1, "R10", {tag, " pme_n after clear"}, 32'(pme_n), 1);
  endtask

  // Scoreboard monitor: judge each frame right after its end byte.
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && in_valid && in_ready && in_eof) begin
        bit    e;
        string t;
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(pme_status == e, "R9", {t, " pme_status"}, 32'(pme_status), 32'(e));
        check(pme_n == !e, "R9", {t, " pme_n"}, 32'(pme_n), 32'(!e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 and R1: reset state
    check(pme_status == 1'b0, "R12", "status in reset", 32'(pme_status), 0);
    check(pme_n == 1'b1, "R12", "pme_n in reset", 32'(pme_n), 1);
    check(in_ready == 1'b0, "R1", "ready in reset", 32'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready after reset", 32'(in_ready), 1);

    // R2: basic pattern
    add_pad(4, 8'h00); add_ff(6); add_addr(16); add_pad(3, 8'h33);
    send_frame(0, 1, 1, 0, 1, "R2 basic");
    clear_status("R2");

    // R1: same frame with idle gaps
    add_ff(6); add_addr(16);
    send_frame(0, 1, 1, 1, 1, "R1 gaps");
    clear_status("R1");

    // R6: bad FCS
    add_ff(6); add_addr(16);
    send_frame(1, 1, 1, 0, 0, "R6 bad crc");

    // R7: filter fail
    add_ff(6); add_addr(16);
    send_frame(0, 0, 1, 0, 0, "R7 filter");

    // R8: disabled
    add_ff(6); add_addr(16);
    send_frame(0, 1, 0, 0, 0, "R8 disabled");

    // R2: only fifteen copies
    add_ff(6); add_addr(15); add_pad(6, 8'h00);
    send_frame(0, 1, 1, 0, 0, "R2 fifteen");

    // R2: sync run of five
    add_pad(2, 8'h01); add_ff(5); add_addr(16);
    send_frame(0, 1, 1, 0, 0, "R2 short sync");

    // R3: long sync run
    add_ff(11); add_addr(16);
    send_frame(0, 1, 1, 0, 1, "R3 long sync");
    clear_status("R3");

    // R4: break on 0xFF that starts a new run
    add_ff(6); add_addr(3); add_ff(6); add_addr(16);
    send_frame(0, 1, 1, 0, 1, "R4 ff restart");
    clear_status("R4");

    // R4: break on a non-0xFF byte, copies continue without sync
    add_ff(6); add_addr(2); pl.push_back(8'h77); add_addr(16);
    send_frame(0, 1, 1, 0, 0, "R4 broken");

    // R5: broken pattern, then a full one later
    add_ff(7); add_addr(9); add_pad(5, 8'h20); add_ff(6); add_addr(16); add_pad(2, 8'h00);
    send_frame(0, 1, 1, 0, 1, "R5 second pattern");

    // R10: sticky through a non-qualifying frame
    add_pad(8, 8'h00);
    send_frame(0, 1, 1, 0, 0, "R10 sticky");
    clear_status("R10");

    // R11: pattern in a frame cut short, then a clean frame with no pattern
    add_ff(6); add_addr(16);
    send_unterminated();
    add_pad(10, 8'h44);
    send_frame(0, 1, 1, 0, 0, "R11 abort");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9", "all frames judged", 32'(exp_q.size()), 0);
    finish_run();
  end

endmodule